// File: doc/BRIEF.md
# Reloading Wake-up Down Timer

This block is a periodic wake-up source for a low-power system. A 24-bit counter steps down once per selected source tick. The tick comes from one of four rate enables that a prescaler outside the block provides. When the count expires, the block does four things:

- it raises a sticky timer flag;
- it reloads the programmed preset;
- it keeps counting, so expiries repeat for as long as the timer runs;
- when enabled, it drives an active-low interrupt pulse of fixed length that releases by itself.

A host programs the block through a small word-wide register port. The preset word sits at address 0. The control word sits at address 1, and the flag at address 2. The control word holds the run bit, the pause bit, the interrupt enable and the source select. Reads are combinational. Address 0 reads back the preset while the timer is stopped and the live count while it runs.

Top module: `wakeup_timer`

## Requirements
- R1: After reset, all three register addresses read as zero and `irq_n` is high.
- R2: While the run bit (control bit 0) is 0, a read of address 0 returns the last value written to address 0.
- R3: A write to address 1 that takes the run bit from 0 to 1 loads the preset into the counter. The counter then drops by one on each selected tick, and address 0 reads the live count while run is 1.
- R4: Control bits 4:3 pick the source: value k selects `src_tick[k]` (0 = 4096 Hz, 1 = 64 Hz, 2 = 1 Hz, 3 = once per minute). Ticks on the other sources leave the count unchanged.
- R5: A selected tick that arrives while the count is 1 sets the flag (address 2, bit 0) and reloads the preset. Counting then repeats without host action.
- R6: While control bit 1 (pause) is 1, the count holds. After pause is cleared, counting resumes from the held value, not from the preset.
- R7: Writing 0 to address 2 bit 0 clears the flag. Writing 1 leaves it unchanged. An expiry in the same cycle as a clear leaves the flag set.
- R8: When control bit 2 (interrupt enable) is 1, each expiry drives `irq_n` low for exactly RET_CYC clock cycles, after which it releases by itself. When bit 2 is 0, an expiry leaves `irq_n` high.
- R9: A control write that clears the interrupt enable returns `irq_n` high from the next clock edge, even if the pulse is still running.
- R10: A preset of 0 counts as a preset of 1, so the timer expires on every selected tick and the count never reaches 0.
- R11: Writing run = 1 again while the timer already runs does not reload the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_tick | input | 4 | One-cycle rate enables, one per selectable source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 preset/count, 1 control, 2 flag) |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Combinational read data for `reg_addr` |
| irq_n | output | 1 | Active-low interrupt pulse |

## Verification
A table of vectors drives every source select with a chosen number of selected ticks plus decoy ticks on a different source. Tick counts below, equal to and above the preset tell plain decrement, a single reload and repeated reloads apart. The full-scale and zero presets test the counter width and the stall guard. Directed sequences pause the timer, restart it and resume it, so that a resume from the held value can be told from a reload. The pulse is measured cycle by cycle, and a second pulse is cut short by clearing the enable, which separates the release by itself from the forced release.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned WDT_N_SRC = 4;
  localparam int unsigned WDT_SEL_W = 2;

  typedef enum logic [1:0] {
    A_PRESET = 2'd0,
    A_CTRL   = 2'd1,
    A_FLAG   = 2'd2
  } wdt_addr_e;

  typedef struct packed {
    logic [WDT_SEL_W-1:0] sel;
    logic                 irq_en;
    logic                 hold;
    logic                 run;
  } wdt_ctrl_t;

  localparam int unsigned WDT_CTRL_W = $bits(wdt_ctrl_t);
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             expire,
  output logic [CNT_W-1:0] preset_q,
  output wdt_ctrl_t        ctrl_q,
  output logic             irq_en_nx,
  output logic             flag_q,
  output logic             start
);
  logic [CNT_W-1:0] preset_d;
  wdt_ctrl_t        ctrl_d;
  logic             flag_d;
  logic             wr_preset, wr_ctrl, wr_flag;

  assign wr_preset = wr_en && (wdt_addr_e'(addr) == A_PRESET);
  assign wr_ctrl   = wr_en && (wdt_addr_e'(addr) == A_CTRL);
  assign wr_flag   = wr_en && (wdt_addr_e'(addr) == A_FLAG);

  always_comb begin
    preset_d = preset_q;
    ctrl_d   = ctrl_q;
    flag_d   = flag_q;
    if (wr_preset) preset_d = wdata;
    if (wr_ctrl)   ctrl_d   = wdt_ctrl_t'(wdata[WDT_CTRL_W-1:0]);
    if (wr_flag && !wdata[0]) flag_d = 1'b0;
    if (expire) flag_d = 1'b1;
  end

  assign start     = ctrl_d.run & ~ctrl_q.run;
  assign irq_en_nx = ctrl_d.irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preset_q <= '0;
      ctrl_q   <= '0;
      flag_q   <= 1'b0;
    end else begin
      preset_q <= preset_d;
      ctrl_q   <= ctrl_d;
      flag_q   <= flag_d;
    end
  end
endmodule

// File: rtl/wdt_tick_sel.sv
module wdt_tick_sel #(
  parameter int unsigned N_SRC = 4,
  parameter int unsigned SEL_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] src_tick,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [N_SRC-1:0] hit;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign hit[g] = src_tick[g] & (sel == SEL_W'(g));
  end

  assign tick = |hit;
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic             hold,
  input  logic             tick,
  input  logic [CNT_W-1:0] preset,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_d, reload;
  logic             step;

  assign reload = (preset == '0) ? CNT_W'(1) : preset;
  assign step   = run & ~hold & tick;
  assign expire = step & (cnt_q == CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (start || expire) cnt_d = reload;
    else if (step)       cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_W'(1);
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdt_irq_pulse.sv
module wdt_irq_pulse #(
  parameter int unsigned RET_CYC = 256,
  parameter int unsigned RET_W   = $clog2(RET_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic en_nx,
  output logic irq_n
);
  logic [RET_W-1:0] left_q, left_d;

  always_comb begin
    left_d = left_q;
    if (!en_nx)              left_d = '0;
    else if (fire)           left_d = RET_W'(RET_CYC);
    else if (left_q != '0)   left_d = left_q - RET_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  assign irq_n = (left_q == '0);
endmodule

// File: rtl/wakeup_timer.sv
module wakeup_timer
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W   = 24,
  parameter int unsigned RET_CYC = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [WDT_N_SRC-1:0] src_tick,
  input  logic                 reg_wr,
  input  logic [1:0]           reg_addr,
  input  logic [CNT_W-1:0]     reg_wdata,
  output logic [CNT_W-1:0]     reg_rdata,
  output logic                 irq_n
);
  localparam int unsigned RET_W = $clog2(RET_CYC + 1);

  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic [CNT_W-1:0] preset_q, cnt_q;
  wdt_ctrl_t        ctrl_q;
  logic             irq_en_nx, flag_q, start, tick, expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  wdt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .expire(expire), .preset_q(preset_q),
    .ctrl_q(ctrl_q), .irq_en_nx(irq_en_nx), .flag_q(flag_q), .start(start)
  );

  wdt_tick_sel #(.N_SRC(WDT_N_SRC), .SEL_W(WDT_SEL_W)) u_sel (
    .src_tick(src_tick), .sel(ctrl_q.sel), .tick(tick)
  );

  wdt_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_sync_n), .start(start), .run(ctrl_q.run),
    .hold(ctrl_q.hold), .tick(tick), .preset(preset_q),
    .cnt_q(cnt_q), .expire(expire)
  );

  wdt_irq_pulse #(.RET_CYC(RET_CYC), .RET_W(RET_W)) u_pulse (
    .clk(clk), .rst_n(rst_sync_n), .fire(expire & ctrl_q.irq_en),
    .en_nx(irq_en_nx), .irq_n(irq_n)
  );

  always_comb begin
    case (wdt_addr_e'(reg_addr))
      A_PRESET: reg_rdata = ctrl_q.run ? cnt_q : preset_q;
      A_CTRL:   reg_rdata = CNT_W'(ctrl_q);
      A_FLAG:   reg_rdata = CNT_W'(flag_q);
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W   = 24,
  parameter int unsigned RET_CYC = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_n,
  input logic             run,
  input logic             hold,
  input logic             irq_en,
  input logic             flag,
  input logic             expire,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] preset,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic             wbit0
);
  localparam int unsigned LOW_W = $clog2(RET_CYC + 2) + 1;
  logic [LOW_W-1:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      low_run <= '0;
    else if (expire) low_run <= '0;
    else if (!irq_n) low_run <= low_run + LOW_W'(1);
    else             low_run <= '0;
  end

  p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> irq_en);

  p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag);

  p_flag_w1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_FLAG && wbit0 && !flag && !expire) |=> !flag);

  p_pause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && hold && !(wr_en && addr == A_CTRL)) |=> $stable(cnt));

  p_cnt_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != '0);

  p_irq_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= LOW_W'(RET_CYC));

  p_start_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> cnt == ((preset == '0) ? CNT_W'(1) : preset));
endmodule

bind wakeup_timer wdt_checker #(.CNT_W(CNT_W), .RET_CYC(RET_CYC)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .irq_n(irq_n), .run(ctrl_q.run),
  .hold(ctrl_q.hold), .irq_en(ctrl_q.irq_en), .flag(flag_q),
  .expire(expire), .cnt(cnt_q), .preset(preset_q), .wr_en(reg_wr),
  .addr(reg_addr), .wbit0(reg_wdata[0])
);

// File: tb/test_wakeup_timer.sv
module test_wakeup_timer;
  localparam int CLK_PERIOD = 10;
  localparam int RET = 256;

  logic        clk, rst_n, reg_wr, irq_n;
  logic [3:0]  src_tick;
  logic [1:0]  reg_addr;
  logic [23:0] reg_wdata, reg_rdata, rv;
  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct packed {
    logic [1:0]  sel;
    logic [23:0] preset;
    logic [7:0]  n_sel;
    logic [7:0]  n_other;
    logic [23:0] exp_cnt;
    logic        exp_flag;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'd0, 24'd5,       8'd3, 8'd2, 24'd2,       1'b0},
    '{2'd1, 24'd5,       8'd5, 8'd3, 24'd5,       1'b1},
    '{2'd2, 24'd3,       8'd7, 8'd1, 24'd2,       1'b1},
    '{2'd3, 24'd10,      8'd0, 8'd4, 24'd10,      1'b0},
    '{2'd0, 24'd0,       8'd3, 8'd2, 24'd1,       1'b1},
    '{2'd2, 24'hFFFFFF,  8'd2, 8'd2, 24'hFFFFFD,  1'b0},
    '{2'd1, 24'd1,       8'd1, 8'd0, 24'd1,       1'b1},
    '{2'd3, 24'd4,       8'd6, 8'd3, 24'd2,       1'b1}
  };

  wakeup_timer i_wakeup_timer (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_n(irq_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [23:0] ctl(input logic [1:0] sel, input logic ien,
                                       input logic hld, input logic run);
    return {19'd0, sel, ien, hld, run};
  endfunction

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [23:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [23:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic tick(input int idx, input int n);
    for (int i = 0; i < n; i++) begin
      src_tick[idx] = 1'b1;
      @(negedge clk);
      src_tick = '0;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int low;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; src_tick = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(2'd0, rv); chk("R1 preset/count", rv, 24'd0);
    rd(2'd1, rv); chk("R1 control", rv, 24'd0);
    rd(2'd2, rv); chk("R1 flag", rv, 24'd0);
    chk("R1 irq_n", {23'd0, irq_n}, 24'd1);

    // R2 readback of preset while stopped, ticks have no effect
    wr(2'd0, 24'h123456);
    tick(0, 2);
    rd(2'd0, rv); chk("R2 preset readback", rv, 24'h123456);

    // Vector table: R3, R4, R5, R10
    for (int v = 0; v < 8; v++) begin
      wr(2'd1, 24'd0);
      wr(2'd2, 24'd0);
      wr(2'd0, VEC[v].preset);
      wr(2'd1, ctl(VEC[v].sel, 1'b0, 1'b0, 1'b1));
      tick(int'(VEC[v].sel), int'(VEC[v].n_sel));
      tick((int'(VEC[v].sel) + 1) % 4, int'(VEC[v].n_other));
      rd(2'd0, rv);
      chk($sformatf("R3/R4/R5/R10 vector %0d count", v), rv, VEC[v].exp_cnt);
      rd(2'd2, rv);
      chk($sformatf("R5 vector %0d flag", v), rv, {23'd0, VEC[v].exp_flag});
    end

    // R11 rewriting run does not reload
    wr(2'd1, 24'd0);
    wr(2'd0, 24'd10);
    wr(2'd1, ctl(2'd0, 1'b0, 1'b0, 1'b1));
    tick(0, 3);
    wr(2'd1, ctl(2'd0, 1'b0, 1'b0, 1'b1));
    rd(2'd0, rv); chk("R11 no reload on re-run", rv, 24'd7);

    // R6 pause and resume
    wr(2'd1, ctl(2'd0, 1'b0, 1'b1, 1'b1));
    tick(0, 4);
    rd(2'd0, rv); chk("R6 paused count", rv, 24'd7);
    wr(2'd1, ctl(2'd0, 1'b0, 1'b0, 1'b1));
    tick(0, 1);
    rd(2'd0, rv); chk("R6 resume from held", rv, 24'd6);

    // R7 flag semantics
    wr(2'd1, 24'd0);
    wr(2'd2, 24'd0);
    wr(2'd0, 24'd2);
    wr(2'd1, ctl(2'd0, 1'b0, 1'b0, 1'b1));
    tick(0, 2);
    rd(2'd2, rv); chk("R7 flag set by expiry", rv, 24'd1);
    wr(2'd2, 24'd1);
    rd(2'd2, rv); chk("R7 write 1 keeps set", rv, 24'd1);
    wr(2'd2, 24'd0);
    rd(2'd2, rv); chk("R7 write 0 clears", rv, 24'd0);
    wr(2'd2, 24'd1);
    rd(2'd2, rv); chk("R7 write 1 does not set", rv, 24'd0);
    // R7 expiry coinciding with clear leaves flag set (count is 2 now)
    tick(0, 1);
    reg_addr = 2'd2; reg_wdata = 24'd0; reg_wr = 1'b1; src_tick[0] = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; src_tick = '0;
    rd(2'd2, rv); chk("R7 expiry wins over clear", rv, 24'd1);

    // R8 no pulse without enable
    wr(2'd1, 24'd0);
    wr(2'd0, 24'd1);
    wr(2'd1, ctl(2'd1, 1'b0, 1'b0, 1'b1));
    tick(1, 1);
    chk("R8 no pulse when disabled", {23'd0, irq_n}, 24'd1);

    // R8 pulse width
    wr(2'd1, ctl(2'd1, 1'b1, 1'b0, 1'b1));
    src_tick[1] = 1'b1;
    @(negedge clk);
    src_tick = '0;
    low = 0;
    while (!irq_n && low < 1000) begin
      low++;
      @(negedge clk);
    end
    chk("R8 pulse width", 24'(low), 24'(RET));

    // R9 early release
    tick(1, 1);
    repeat (10) @(negedge clk);
    chk("R9 pulse active", {23'd0, irq_n}, 24'd0);
    wr(2'd1, ctl(2'd1, 1'b0, 1'b0, 1'b1));
    chk("R9 released on clear", {23'd0, irq_n}, 24'd1);

    finish_run();
  end
endmodule